// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines into one interrupt signal for a processor. Each line is captured on its rising edge into a pending register. A mask register removes selected lines from arbitration without discarding their captured requests. Among the unmasked pending lines, the lowest-numbered one wins.

An in-service register records which lines the processor is currently handling. The interrupt output is raised only when the winning pending line strictly outranks every line in service. This allows nesting: a more urgent line preempts a less urgent one, while equal or lower lines wait.

When the processor acknowledges, the winner moves from pending to in-service. One cycle later the block presents an 8-bit vector, built from a programmable 5-bit base and the 3-bit line number. An end-of-interrupt pulse retires the most urgent in-service line.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset, nothing is pending or in service, the mask is all zeros (every line enabled), the base is zero, and `int_out`, `vec_valid` and `vec_out` are 0.
- R2: A request is captured only on a 0-to-1 transition of `irq_in[i]` seen at a clock edge. A line held high captures once and does not capture again after its acknowledge.
- R3: A line whose bit is 1 in the mask (written through `cfg_wr`/`cfg_mask`) takes no part in arbitration. Its captured request is kept, and it competes again once unmasked.
- R4: Among unmasked pending lines, the lowest line number has the highest priority and wins.
- R5: `int_out` is 1 exactly when some unmasked line is pending and the winner's number is lower than the number of every in-service line (or nothing is in service). A strictly more urgent line therefore preempts.
- R6: An `ack` sampled while `int_out` is 1 clears the winner's pending bit and sets its in-service bit. In the next cycle `vec_valid` is 1 for one cycle, and `vec_out` holds the base in bits 7:3 and the winner's line number in bits 2:0.
- R7: An `ack` sampled while `int_out` is 0 is ignored: `vec_valid` stays 0 and no pending or in-service state changes.
- R8: An `eoi` pulse clears only the lowest-numbered (most urgent) in-service bit. Deeper nested lines stay in service and keep blocking requests of equal or lower urgency.
- R9: A new request on a line that is itself in service, or on a less urgent line, does not raise `int_out` until the blocking in-service line is retired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines, captured on rising edge |
| cfg_wr | input | 1 | Loads mask and vector base |
| cfg_mask | input | 8 | Mask value, 1 disables a line |
| cfg_base | input | 5 | Upper five vector bits |
| ack | input | 1 | Processor acknowledge pulse |
| eoi | input | 1 | End-of-interrupt pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after an accepted acknowledge |
| vec_out | output | 8 | {base, winning line number} |

## Verification
The assertions check four properties on every cycle. An accepted acknowledge always yields the right vector on the next cycle. An ignored acknowledge, or a cycle with no acknowledge, never produces a vector. The interrupt output never stands for a masked or non-outranking request. Every end-of-interrupt without a concurrent acknowledge removes exactly one in-service bit.

Edge-only capture, retention of masked requests, and the order in which nested lines are retired depend on stimulus history, so only the bench's scenarios show them. These include a sweep over every ordered pair of lines, three-deep nesting, and a line held high through its own service.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int NUM_IRQ = 8;
    localparam int ID_W    = $clog2(NUM_IRQ);
    localparam int BASE_W  = 5;
    localparam int VEC_W   = BASE_W + ID_W;

    typedef logic [NUM_IRQ-1:0] irq_vec_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [ID_W-1:0]   id;
    } vector_t;

    typedef struct packed {
        logic             found;
        logic [ID_W-1:0]  idx;
        irq_vec_t         onehot;
    } pick_t;

    function automatic vector_t make_vector(logic [BASE_W-1:0] b, logic [ID_W-1:0] i);
        vector_t v;
        v.base = b;
        v.id   = i;
        return v;
    endfunction

    // candidate strictly more urgent than the current in-service top
    function automatic logic outranks(pick_t cand, pick_t cur);
        return cand.found && (!cur.found || (cand.idx < cur.idx));
    endfunction
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_prio_pkg::*;
(
    input  irq_vec_t bits,
    output pick_t    res
);
    logic [NUM_IRQ:0] seen;
    irq_vec_t         hot;
    logic [ID_W-1:0]  idx;

    assign seen[0] = 1'b0;

    generate
        for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chain
            assign seen[g+1] = seen[g] | bits[g];
            assign hot[g]    = bits[g] & ~seen[g];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (hot[i]) idx = idx | ID_W'(i);
        end
    end

    assign res.found  = seen[NUM_IRQ];
    assign res.idx    = idx;
    assign res.onehot = hot;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_prio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t irq_in,
    input  irq_vec_t clr,
    output irq_vec_t req
);
    irq_vec_t prev_q;
    irq_vec_t req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            req_q  <= '0;
        end else begin
            prev_q <= irq_in;
            req_q  <= (req_q & ~clr) | (irq_in & ~prev_q);
        end
    end

    assign req = req_q;
endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track
    import irq_prio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t set,
    input  logic     eoi,
    output irq_vec_t isr,
    output pick_t    top
);
    irq_vec_t isr_q;
    irq_vec_t retire;

    irq_prio_pick u_top (
        .bits (isr_q),
        .res  (top)
    );

    assign retire = eoi ? top.onehot : '0;

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= (isr_q & ~retire) | set;
    end

    assign isr = isr_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               cfg_wr,
    input  logic [NUM_IRQ-1:0] cfg_mask,
    input  logic [BASE_W-1:0]  cfg_base,
    input  logic               ack,
    input  logic               eoi,
    output logic               int_out,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_out
);
    irq_vec_t          mask_q;
    logic [BASE_W-1:0] base_q;
    irq_vec_t          req_q;
    irq_vec_t          isr_q;
    irq_vec_t          grant;
    pick_t             pend_pick;
    pick_t             isr_pick;
    logic [ID_W-1:0]   win_idx;
    logic [ID_W-1:0]   isr_idx;
    logic              accept;
    vector_t           vec_q;
    logic              vec_valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            base_q <= '0;
        end else if (cfg_wr) begin
            mask_q <= cfg_mask;
            base_q <= cfg_base;
        end
    end

    irq_req_latch u_req (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .clr    (grant),
        .req    (req_q)
    );

    irq_prio_pick u_pend (
        .bits (req_q & ~mask_q),
        .res  (pend_pick)
    );

    irq_isr_track u_isr (
        .clk (clk),
        .rst (rst),
        .set (grant),
        .eoi (eoi),
        .isr (isr_q),
        .top (isr_pick)
    );

    assign win_idx = pend_pick.idx;
    assign isr_idx = isr_pick.idx;
    assign int_out = outranks(pend_pick, isr_pick);
    assign accept  = ack & int_out;
    assign grant   = accept ? pend_pick.onehot : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q       <= '0;
            vec_valid_q <= 1'b0;
        end else begin
            vec_valid_q <= accept;
            if (accept) vec_q <= make_vector(base_q, win_idx);
        end
    end

    assign vec_valid = vec_valid_q;
    assign vec_out   = vec_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ack,
    input logic               eoi,
    input logic               int_out,
    input logic               vec_valid,
    input logic [VEC_W-1:0]   vec_out,
    input logic [NUM_IRQ-1:0] req_q,
    input logic [NUM_IRQ-1:0] mask_q,
    input logic [NUM_IRQ-1:0] isr_q,
    input logic [BASE_W-1:0]  base_q,
    input logic [ID_W-1:0]    win_idx,
    input logic [ID_W-1:0]    isr_idx
);
    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (isr_q == '0 && req_q == '0 && !vec_valid)); // R1

    AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (ack && int_out) |=> (vec_valid && vec_out == {$past(base_q), $past(win_idx)})); // R6

    AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_out) |=> (!vec_valid && $stable(isr_q))); // R7

    AST_NO_STRAY_VECTOR: assert property (@(posedge clk) disable iff (rst)
        !ack |=> !vec_valid); // R7

    AST_MASK_HONOURED: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((req_q & ~mask_q) != '0)); // R3

    AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (int_out && isr_q != '0) |-> (win_idx < isr_idx)); // R5

    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (rst)
        (eoi && !ack && isr_q != '0) |=> ($countones(isr_q) + 1 == $countones($past(isr_q)))); // R8
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk chk_i (.*);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_mask = '0;
    logic [4:0] cfg_base = '0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       int_out;
    logic       vec_valid;
    logic [7:0] vec_out;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_req  = '0;
    logic [7:0] m_isr  = '0;
    logic [7:0] m_mask = '0;
    logic [4:0] m_base = '0;

    always #2 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .cfg_wr    (cfg_wr),
        .cfg_mask  (cfg_mask),
        .cfg_base  (cfg_base),
        .ack       (ack),
        .eoi       (eoi),
        .int_out   (int_out),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );

    function automatic int lowest(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic logic model_int();
        logic [7:0] p = m_req & ~m_mask;
        if (p == '0) return 1'b0;
        return lowest(p) < lowest(m_isr);
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(int i, string tag);
        irq_in[i] = 1'b1;
        step();
        irq_in[i] = 1'b0;
        step();
        m_req[i] = 1'b1;
        check(tag, int'(int_out), int'(model_int()));
    endtask

    task automatic do_ack(string tag);
        logic exp_v = model_int();
        int   w     = lowest(m_req & ~m_mask);
        ack = 1'b1;
        step();
        ack = 1'b0;
        check({tag, " vec_valid"}, int'(vec_valid), int'(exp_v));
        if (exp_v) begin
            check({tag, " vec_out"}, int'(vec_out), int'({m_base, 3'(w)}));
            m_req[w] = 1'b0;
            m_isr[w] = 1'b1;
        end
        check({tag, " int_out after ack R5"}, int'(int_out), int'(model_int()));
    endtask

    task automatic do_eoi(string tag);
        eoi = 1'b1;
        step();
        eoi = 1'b0;
        if (m_isr != '0) m_isr[lowest(m_isr)] = 1'b0;
        check(tag, int'(int_out), int'(model_int()));
    endtask

    task automatic do_cfg(logic [7:0] m, logic [4:0] b);
        cfg_wr = 1'b1; cfg_mask = m; cfg_base = b;
        step();
        cfg_wr = 1'b0;
        m_mask = m; m_base = b;
    endtask

    task automatic drain(string tag);
        for (int k = 0; k < 20; k++) begin
            if (m_isr == '0 && (m_req & ~m_mask) == '0) break;
            if (model_int()) do_ack(tag);
            else do_eoi({tag, " eoi R8"});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        rst = 1'b0;
        step();
        // R1 reset state
        check("R1 int_out", int'(int_out), 0);
        check("R1 vec_valid", int'(vec_valid), 0);
        check("R1 vec_out", int'(vec_out), 0);

        // R7 ack with nothing pending
        do_ack("R7 idle ack");

        // R6 single-line sweep with varying base
        for (int i = 0; i < 8; i++) begin
            do_cfg(8'h00, 5'((i * 7 + 3) % 32));
            pulse(i, "R5 single raise");
            check("R5 single int", int'(int_out), 1);
            do_ack("R6 single");
            do_eoi("R8 single eoi");
        end

        // R2 line held high captures once
        irq_in[3] = 1'b1;
        step();
        m_req[3] = 1'b1;
        check("R2 held capture", int'(int_out), 1);
        do_ack("R6 held");
        repeat (3) step();
        do_eoi("R2 held eoi");
        check("R2 no recapture", int'(int_out), 0);
        irq_in[3] = 1'b0;
        step();
        check("R2 after release", int'(int_out), 0);

        // R4 simultaneous captures
        do_cfg(8'h00, 5'd17);
        irq_in = 8'b1010_0100;
        step();
        irq_in = '0;
        step();
        m_req = m_req | 8'b1010_0100;
        check("R4 multi int", int'(int_out), 1);
        do_ack("R4 multi winner");
        drain("R4 multi drain");

        // R5 R9 sweep over ordered pairs
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                pulse(a, "R5 pair first");
                do_ack("R6 pair first");
                pulse(b, (b < a) ? "R5 pair preempt" : "R9 pair wait");
                drain("R4 pair drain");
                check("R8 pair idle", int'(int_out), 0);
            end
        end

        // R3 masking keeps request
        do_cfg(8'b0000_0100, 5'd9);
        pulse(2, "R3 masked raise");
        check("R3 masked no int", int'(int_out), 0);
        pulse(5, "R3 other line");
        do_ack("R3 bypass mask");
        do_eoi("R8 mask eoi");
        check("R3 still hidden", int'(int_out), 0);
        do_cfg(8'h00, 5'd9);
        check("R3 unmasked int", int'(int_out), 1);
        do_ack("R3 unmasked vector");
        do_eoi("R8 unmask eoi");

        // R7 ack while blocked by service
        pulse(4, "R5 block setup");
        do_ack("R6 block setup");
        pulse(6, "R9 blocked lower");
        do_ack("R7 blocked ack");
        check("R7 still pending", int'(int_out), 0);
        do_eoi("R8 unblock");
        check("R7 released int", int'(int_out), 1);
        do_ack("R7 late vector");
        do_eoi("R8 block end");

        // R8 three-deep nesting
        do_cfg(8'h00, 5'd30);
        pulse(5, "R5 nest a");
        do_ack("R6 nest a");
        pulse(3, "R5 nest b");
        do_ack("R6 nest b");
        pulse(1, "R5 nest c");
        do_ack("R6 nest c");
        do_eoi("R8 retire c");
        pulse(4, "R9 nest blocked");
        check("R8 deeper blocks", int'(int_out), 0);
        do_eoi("R8 retire b");
        check("R8 now outranks", int'(int_out), 1);
        drain("R8 nest drain");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule